// File: doc/BRIEF.md
# SAR converter control-line decoder

This block holds the digital control side of a 12-bit sampling converter with a parallel output. Two active-low control lines drive it: a chip select and a read/convert line. When both lines are low together, the block starts a conversion. When select is low and read/convert is high, the block reads the result out.

A conversion runs for a fixed number of system clock cycles. For that whole time the busy output stays low. When the count ends, the block captures a two's complement result from a stimulus port. Then it raises busy and, if the read condition holds, drives the result onto a tri-state bus.

The two control lines are combined by level, so either line may be the last one to go low. The block screens start commands for two faults:
- A start condition shorter than the minimum width is ignored and reported.
- A start that comes while a conversion is running, or too soon after the previous accepted start, is ignored and reported.

All control inputs are sampled by one register stage on the system clock. Every timing figure below counts rising clock edges at which both sampled lines are low.

Top module: `sar_ctl_decoder`

## Requirements
- R1: While reset is asserted, busy_n is 1, dbus_en is 0, and both error flags are 0.
- R2: A conversion starts when cs_n and rd_conv are both sampled low on MIN_LOW consecutive edges, whichever line fell last. busy_n is still 1 after the MIN_LOW-th edge and falls on the next edge.
- R3: busy_n stays low for exactly CONV_CYC cycles. At the edge where it rises, the result register loads the value present on sample_code.
- R4: A start condition that lasts fewer than MIN_LOW edges starts nothing and leaves the result unchanged. err_short pulses for one cycle, beginning on the second edge that samples the condition released.
- R5: A start condition that qualifies while busy_n is low is ignored and does not change the end time of the running conversion. err_early pulses for one cycle, on the edge where busy_n would otherwise have fallen.
- R6: dbus_en is 1 only when cs_n is sampled low, rd_conv is sampled high and busy_n is 1. dbus is high-impedance whenever dbus_en is 0.
- R7: Two accepted starts are never fewer than MIN_GAP cycles apart. A start that qualifies earlier is ignored and flagged through err_early, as in R5, even when busy_n is already high.
- R8: If the read condition holds when busy_n rises, dbus_en rises on that same edge and dbus carries the new result.
- R9: The result is stored bit for bit as 12-bit two's complement, with the sign in bit 11. 7FF is the top code, 800 the bottom code, 000 is zero and FFF is minus one.
- R10: A start condition held low across and beyond a whole conversion counts as one command. It starts exactly one conversion and raises no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cs_n | input | 1 | Active-low chip select |
| rd_conv | input | 1 | Read (high) / convert (low) line |
| sample_code | input | DATA_W (12) | Conversion result supplied by the stimulus, two's complement |
| busy_n | output | 1 | Low while a conversion is in progress |
| dbus | output | DATA_W (12) | Tri-state result bus |
| dbus_en | output | 1 | High while dbus is driven |
| err_short | output | 1 | One-cycle pulse: start condition too short |
| err_early | output | 1 | One-cycle pulse: start while busy or before the minimum spacing |

## Verification
Two functions can coincide in one cycle: the end of a conversion and the opening of the read path. The bench provokes this by releasing rd_conv high while cs_n stays low, in the middle of a conversion. The bus must stay off until busy_n rises. On the very edge where busy_n rises, dbus_en must be 1 and dbus must already show the newly captured code, never the previous one. The bench also fires start commands one cycle before and exactly at the spacing limit. It confirms that a start arriving during a conversion leaves the completion edge unchanged.

// File: rtl/sar_ctl_pkg.sv
package sar_ctl_pkg;
  typedef enum logic {
    SEQ_IDLE = 1'b0,
    SEQ_CONV = 1'b1
  } seq_state_t;
endpackage

// File: rtl/sar_cmd_qual.sv
// Samples the control lines and qualifies a start condition by width.
module sar_cmd_qual #(
  parameter int MIN_LOW = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic rd_conv,
  output logic cs_q,
  output logic rd_q,
  output logic qual,
  output logic err_short
);
  localparam int CW = $clog2(MIN_LOW + 1);

  logic          lvl;
  logic [CW-1:0] lo_cnt, lo_cnt_nx;

  always_comb begin
    lvl       = ~cs_q & ~rd_q;
    lo_cnt_nx = lo_cnt;
    if (!lvl)
      lo_cnt_nx = '0;
    else if (lo_cnt != CW'(MIN_LOW))
      lo_cnt_nx = lo_cnt + 1'b1;
    qual      = lvl && (lo_cnt == CW'(MIN_LOW - 1));
    err_short = !lvl && (lo_cnt != '0) && (lo_cnt < CW'(MIN_LOW));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_q   <= 1'b1;
      rd_q   <= 1'b1;
      lo_cnt <= '0;
    end else begin
      cs_q   <= cs_n;
      rd_q   <= rd_conv;
      lo_cnt <= lo_cnt_nx;
    end
  end

  // R10
  single_qual_chk: assert property (@(posedge clk) disable iff (!rst_n)
    qual |=> !qual);
endmodule

// File: rtl/sar_conv_seq.sv
// Conversion sequencer: busy window, start spacing, result capture.
module sar_conv_seq
  import sar_ctl_pkg::*;
#(
  parameter int DATA_W   = 12,
  parameter int CONV_CYC = 340,
  parameter int MIN_GAP  = 415
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              qual,
  input  logic [DATA_W-1:0] sample_code,
  output logic              busy_n,
  output logic [DATA_W-1:0] result,
  output logic              err_early
);
  localparam int TW  = $clog2(CONV_CYC + 1);
  localparam int GW  = $clog2(MIN_GAP + 1);
  localparam int LRW = $clog2(CONV_CYC + 2);

  seq_state_t    state, state_nx;
  logic [TW-1:0] conv_cnt, conv_cnt_nx;
  logic [GW-1:0] gap_rem, gap_rem_nx;
  logic          accept, load_res, err_nx;

  always_comb begin
    accept      = qual && (state == SEQ_IDLE) && (gap_rem == '0);
    load_res    = (state == SEQ_CONV) && (conv_cnt == '0);
    state_nx    = state;
    conv_cnt_nx = conv_cnt;
    gap_rem_nx  = gap_rem;
    if (gap_rem != '0)
      gap_rem_nx = gap_rem - 1'b1;
    case (state)
      SEQ_IDLE: begin
        if (accept) begin
          state_nx    = SEQ_CONV;
          conv_cnt_nx = TW'(CONV_CYC - 1);
          gap_rem_nx  = GW'(MIN_GAP - 1);
        end
      end
      SEQ_CONV: begin
        if (load_res)
          state_nx = SEQ_IDLE;
        else
          conv_cnt_nx = conv_cnt - 1'b1;
      end
    endcase
    err_nx = qual && !accept;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= SEQ_IDLE;
      conv_cnt  <= '0;
      gap_rem   <= '0;
      err_early <= 1'b0;
    end else begin
      state     <= state_nx;
      conv_cnt  <= conv_cnt_nx;
      gap_rem   <= gap_rem_nx;
      err_early <= err_nx;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      result <= '0;
    else if (load_res)
      result <= sample_code;
  end

  assign busy_n = (state == SEQ_IDLE);

  // Checker state, independent of the sequencer counters
  logic           busy_prev;
  logic [LRW-1:0] lo_run;
  logic [GW-1:0]  since_fall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_prev  <= 1'b1;
      lo_run     <= '0;
      since_fall <= GW'(MIN_GAP);
    end else begin
      busy_prev <= busy_n;
      if (busy_n)
        lo_run <= '0;
      else if (lo_run != LRW'(CONV_CYC + 1))
        lo_run <= lo_run + 1'b1;
      if (busy_prev && !busy_n)
        since_fall <= GW'(1);
      else if (since_fall != GW'(MIN_GAP))
        since_fall <= since_fall + 1'b1;
    end
  end

  // R2
  start_needs_qual_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_n) |-> $past(qual));
  // R3
  busy_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_prev && busy_n) |-> (lo_run == LRW'(CONV_CYC)));
  // R7
  start_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_prev && !busy_n) |-> (since_fall >= GW'(MIN_GAP)));
endmodule

// File: rtl/sar_bus_ctl.sv
// Read-path decode for the parallel result bus.
module sar_bus_ctl #(
  parameter int DATA_W = 12
) (
  input  logic              cs_q,
  input  logic              rd_q,
  input  logic              busy_n,
  input  logic [DATA_W-1:0] result,
  output logic              drive_en,
  output logic [DATA_W-1:0] drive_data
);
  always_comb begin
    drive_en   = ~cs_q & rd_q & busy_n;
    drive_data = drive_en ? result : '0;
  end
endmodule

// File: rtl/sar_ctl_decoder.sv
module sar_ctl_decoder #(
  parameter int DATA_W   = 12,
  parameter int MIN_LOW  = 10,
  parameter int CONV_CYC = 340,
  parameter int MIN_GAP  = 415
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              rd_conv,
  input  logic [DATA_W-1:0] sample_code,
  output logic              busy_n,
  output logic [DATA_W-1:0] dbus,
  output logic              dbus_en,
  output logic              err_short,
  output logic              err_early
);
  logic [1:0]        rst_pipe;
  logic              rst_core;
  logic              cs_q, rd_q, qual;
  logic [DATA_W-1:0] result, drive_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      rst_pipe <= '0;
    else
      rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_core = rst_pipe[1];

  sar_cmd_qual #(.MIN_LOW(MIN_LOW)) u_qual (
    .clk(clk), .rst_n(rst_core), .cs_n(cs_n), .rd_conv(rd_conv),
    .cs_q(cs_q), .rd_q(rd_q), .qual(qual), .err_short(err_short)
  );

  sar_conv_seq #(.DATA_W(DATA_W), .CONV_CYC(CONV_CYC), .MIN_GAP(MIN_GAP)) u_seq (
    .clk(clk), .rst_n(rst_core), .qual(qual), .sample_code(sample_code),
    .busy_n(busy_n), .result(result), .err_early(err_early)
  );

  sar_bus_ctl #(.DATA_W(DATA_W)) u_bus (
    .cs_q(cs_q), .rd_q(rd_q), .busy_n(busy_n), .result(result),
    .drive_en(dbus_en), .drive_data(drive_data)
  );

  assign dbus = dbus_en ? drive_data : {DATA_W{1'bz}};

  // R6
  bus_idle_only_chk: assert property (@(posedge clk) disable iff (!rst_core)
    dbus_en |-> busy_n);
  // R4
  short_no_start_chk: assert property (@(posedge clk) disable iff (!rst_core)
    err_short |-> !$fell(busy_n));
  // R5
  early_no_start_chk: assert property (@(posedge clk) disable iff (!rst_core)
    err_early |-> !$fell(busy_n));
endmodule

// File: tb/test_sar_ctl_decoder.sv
module test_sar_ctl_decoder;
  localparam int DW = 12;
  localparam int M  = 10;
  localparam int C  = 340;
  localparam int G  = 415;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cs_n = 1'b1;
  logic          rd_conv = 1'b1;
  logic [DW-1:0] code = '0;
  logic          busy_n, dbus_en, err_short, err_early;
  logic [DW-1:0] dbus;

  always #2 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_chk = 0, n_fail = 0, d_last = 0;
  bit finished = 0;
  logic [DW-1:0] last_res = '0;

  sar_ctl_decoder #(.DATA_W(DW), .MIN_LOW(M), .CONV_CYC(C), .MIN_GAP(G)) i_sar_ctl_decoder (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_conv(rd_conv), .sample_code(code),
    .busy_n(busy_n), .dbus(dbus), .dbus_en(dbus_en),
    .err_short(err_short), .err_early(err_early)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_until(input int t);
    while (cyc < t) @(negedge clk);
  endtask

  function automatic bool_started(input int len);
    return len >= M;
  endfunction

  function automatic int exp_short_at(input int len);
    return (len < M) ? len + 1 : -1;
  endfunction

  // order: 0 rd_conv falls first, 1 cs_n falls first, 2 both together
  task automatic launch(input int order, input int len, input bit rd_after,
                        output int short_at, output int early_at,
                        output bit b_m, output bit b_m1);
    int last;
    if (order == 0) begin rd_conv = 1'b0; step(1); end
    if (order == 1) begin cs_n = 1'b0; step(1); end
    cs_n = 1'b0; rd_conv = 1'b0;
    d_last = cyc;
    short_at = -1; early_at = -1; b_m = 1'b0; b_m1 = 1'b0;
    last = ((len > M) ? len : M) + 2;
    for (int i = 1; i <= last; i++) begin
      if (i == len + 1) begin
        cs_n = rd_after ? 1'b0 : 1'b1;
        rd_conv = 1'b1;
      end
      step(1);
      if (err_short) short_at = i;
      if (err_early) early_at = i;
      if (i == M) b_m = busy_n;
      if (i == M + 1) b_m1 = busy_n;
    end
  endtask

  task automatic idle_lines();
    cs_n = 1'b1; rd_conv = 1'b1;
  endtask

  task automatic run_one(input int order, input int len, input bit rd_after,
                         input logic [DW-1:0] v);
    int sa, ea; bit bm, bm1, st;
    code = v;
    st = bool_started(len);
    launch(order, len, rd_after, sa, ea, bm, bm1);
    chk(bm == 1'b1, "R2 busy high up to min width", bm, 1);
    if (st) chk(bm1 == 1'b0, "R2 start after min width", bm1, 0);
    else    chk(bm1 == 1'b1, "R4 short pulse starts nothing", bm1, 1);
    chk(sa == exp_short_at(len), "R4 err_short timing", sa, exp_short_at(len));
    chk(ea == -1, "R5 no err_early", ea, -1);
    if (st) begin
      wait_until(d_last + M + C);
      chk(busy_n == 1'b0, "R3 busy held low", busy_n, 0);
      if (rd_after) chk(dbus_en == 1'b0, "R6 bus off while busy", dbus_en, 0);
      step(1);
      chk(busy_n == 1'b1, "R3 busy rises after CONV_CYC", busy_n, 1);
      if (rd_after) begin
        chk(dbus_en == 1'b1, "R8 bus on with busy rise", dbus_en, 1);
        chk(dbus == v, "R8 R9 new data on busy rise", dbus, v);
      end else begin
        chk(dbus_en == 1'b0, "R6 bus off with select high", dbus_en, 0);
      end
      last_res = v;
    end else if (rd_after) begin
      chk(dbus_en == 1'b1 && dbus == last_res, "R4 result unchanged", dbus, last_res);
    end
    idle_lines();
    step(1);
    chk(dbus_en == 1'b0, "R6 bus off after release", dbus_en, 0);
    wait_until(d_last + G + 2);
  endtask

  task automatic read_check(input logic [DW-1:0] v, input string req);
    cs_n = 1'b0; rd_conv = 1'b1;
    step(1);
    chk(dbus_en == 1'b1 && dbus == v, req, dbus, v);
    idle_lines();
    step(1);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      summary();
      $finish;
    end
  end

  initial begin
    int sa, ea, d0, seed; bit bm, bm1;
    seed = $urandom(32'd20531);
    step(3);
    // R1 reset state
    chk(busy_n == 1'b1, "R1 busy_n in reset", busy_n, 1);
    chk(dbus_en == 1'b0, "R1 bus off in reset", dbus_en, 0);
    chk(err_short == 1'b0 && err_early == 1'b0, "R1 flags in reset", err_short, 0);
    rst_n = 1'b1;
    step(5);

    // R2 R8 R9: both together, exact width, read held at completion, top code
    run_one(2, M, 1'b1, 12'h7FF);
    // R2 R9: chip select falls last, bottom code, read later
    run_one(0, M + 2, 1'b0, 12'h800);
    read_check(12'h800, "R9 bottom code read back");
    // R2 R9: read/convert falls last, zero and minus one
    run_one(1, M, 1'b1, 12'h000);
    run_one(2, M + 1, 1'b1, 12'hFFF);
    // R4 short pulses, one cycle below the limit, and a single edge
    run_one(1, M - 1, 1'b1, 12'h3C5);
    run_one(0, 1, 1'b1, 12'h2AA);

    // R5: start during busy ignored, end time unchanged
    code = 12'h123;
    launch(2, M, 1'b0, sa, ea, bm, bm1);
    d0 = d_last;
    idle_lines();
    step(40);
    code = 12'h456;
    launch(2, M, 1'b0, sa, ea, bm, bm1);
    chk(ea == M + 1, "R5 err_early while busy", ea, M + 1);
    chk(bm1 == 1'b0, "R5 busy kept", bm1, 0);
    idle_lines();
    wait_until(d0 + M + C);
    chk(busy_n == 1'b0, "R5 end not moved (still busy)", busy_n, 0);
    step(1);
    chk(busy_n == 1'b1, "R5 end not moved (rise)", busy_n, 1);
    read_check(12'h456, "R3 result taken at end");
    last_res = 12'h456;
    wait_until(d0 + G + 2);

    // R7: one cycle too early
    code = 12'h111;
    launch(2, M, 1'b0, sa, ea, bm, bm1);
    d0 = d_last;
    idle_lines();
    wait_until(d0 + G - 1);
    launch(2, M, 1'b0, sa, ea, bm, bm1);
    chk(ea == M + 1, "R7 early start flagged", ea, M + 1);
    chk(bm1 == 1'b1, "R7 early start ignored", bm1, 1);
    idle_lines();
    wait_until(d0 + G + 40);
    // R7: exactly at the spacing limit
    launch(2, M, 1'b0, sa, ea, bm, bm1);
    d0 = d_last;
    idle_lines();
    wait_until(d0 + G);
    launch(2, M, 1'b0, sa, ea, bm, bm1);
    chk(bm1 == 1'b0, "R7 start at limit accepted", bm1, 0);
    chk(ea == -1, "R7 no flag at limit", ea, -1);
    idle_lines();
    last_res = 12'h111;
    wait_until(d_last + G + 2);

    // R10: start held across a whole conversion
    code = 12'h5A5;
    launch(2, C + M + 20, 1'b0, sa, ea, bm, bm1);
    chk(bm1 == 1'b0, "R10 held start begins", bm1, 0);
    chk(busy_n == 1'b1, "R10 no second conversion", busy_n, 1);
    chk(ea == -1 && sa == -1, "R10 no error flags", ea, -1);
    idle_lines();
    last_res = 12'h5A5;
    wait_until(d_last + G + 2);

    // Random mix
    for (int k = 0; k < 16; k++) begin
      int ord, len; bit rd;
      ord = int'($urandom_range(2, 0));
      len = int'($urandom_range(M + 3, M - 2));
      rd  = 1'($urandom_range(1, 0));
      run_one(ord, len, rd, DW'($urandom));
    end

    finished = 1;
    summary();
    $finish;
  end
endmodule